// File: doc/BRIEF.md
# Multi-Mode DDR Output Path

This block carries data from core logic to one pad. A static two-bit mode code selects one of four routes. The first skips every register. The second uses the full-rate stage as a plain single-edge register. The third uses that stage as a double-data-rate register. The fourth places a half-rate stage in front of the full-rate DDR stage. The half-rate stage takes a four-bit word once per half-rate cycle and turns it into two bit pairs, one pair per full-rate cycle.

Every route ends in a delay stage of `DLY` full-rate cycles, and that delay is the same in every mode. The stage carries two bits per cycle: one for the high phase of the full-rate clock and one for the low phase. An output enable moves through a matching delay beside the data. All registers share one active-low asynchronous clear and one active-low asynchronous preset. Clear wins when both are asserted. The full-rate clock runs at exactly twice the half-rate clock frequency, with rising edges aligned.

Top module: `ddr_out_path`

## Requirements
- R1: The mode code selects the route: 0 = bypass, 1 = packed register, 2 = full-rate DDR, 3 = half-rate DDR. The code is changed only while clear is asserted.
- R2: In bypass mode, a value applied to `data_in[0]` just after rising full-rate edge n is driven on `pad_out` for the whole full-rate cycle that follows edge n+DLY.
- R3: In packed-register mode, `data_in[0]` is captured on a rising full-rate edge n and driven in both phases of the cycle that follows edge n+DLY.
- R4: In full-rate DDR mode, `data_in[0]` and `data_in[1]` are captured at full-rate edge n. In the cycle after edge n+DLY, `data_in[0]` is driven while `clk_full` is high and `data_in[1]` while it is low.
- R5: In half-rate DDR mode, `data_in[3:0]` is captured on a rising half-rate edge m. In the cycle after full-rate edge m+1+DLY, bit 0 is driven in the high phase and bit 1 in the low phase. In the next cycle, bit 2 is driven in the high phase and bit 3 in the low phase.
- R6: While `clr_n` is low, `pad_out` and `pad_oe` are 0, whatever the clocks and `set_n` do. Clear takes effect without waiting for a clock.
- R7: While `set_n` is low and `clr_n` is high, `pad_out` is 1 in both phases and `pad_oe` is 0. Preset takes effect without waiting for a clock.
- R8: In every mode, `oe_in` sampled just after full-rate edge n appears on `pad_oe` for the cycle that follows edge n+DLY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_half | input | 1 | Half-rate clock, rising edges aligned with `clk_full` |
| clk_full | input | 1 | Full-rate clock, twice the half-rate frequency |
| clr_n | input | 1 | Asynchronous clear, active low, has priority |
| set_n | input | 1 | Asynchronous preset, active low |
| mode | input | 2 | Route select (0 bypass, 1 packed, 2 full DDR, 3 half DDR) |
| data_in | input | 4 | Core data word |
| oe_in | input | 1 | Output enable from the enable path |
| pad_out | output | 1 | Pad data after the delay stage |
| pad_oe | output | 1 | Pad output enable after the delay stage |

## Verification
Each mode runs with a fresh random word every full-rate cycle, and half-rate mode gets a fresh word on every half-rate edge. The bench compares both phases of every cycle against a queue model. These random runs separate high-phase bits from low-phase bits, which catches swapped DDR order and swapped bit pairs in half-rate mode. They also catch an off-by-one in the delay, because the bypass latency and the registered latency differ by one cycle. Independent random toggling of the enable shows that its delay matches the data path. A final sequence asserts preset, then clear on top of it, to show that each forces its value between clock edges and that clear has priority.

// File: rtl/ddr_out_path.sv
module ddr_out_path #(
  parameter int DLY = 2
) (
  input  logic       clk_half,
  input  logic       clk_full,
  input  logic       clr_n,
  input  logic       set_n,
  input  logic [1:0] mode,
  input  logic [3:0] data_in,
  input  logic       oe_in,
  output logic       pad_out,
  output logic       pad_oe
);
  localparam logic [1:0] M_BYP = 2'd0;
  localparam logic [1:0] M_REG = 2'd1;
  localparam logic [1:0] M_FDR = 2'd2;
  localparam logic [1:0] M_HDR = 2'd3;
  localparam int LAST = DLY - 1;

  logic [3:0] hr_word;
  logic       hr_tog;
  logic       tog_seen, ph;
  logic [1:0] fr_pair, fr_next, chain_in;
  logic [1:0] dq [DLY];
  logic       oq [DLY];
  logic       first;

  // half-rate capture; the toggle marks each new word for the full-rate side
  always_ff @(posedge clk_half or negedge clr_n or negedge set_n)
    if (!clr_n) begin
      hr_word <= '0;
      hr_tog  <= 1'b0;
    end else if (!set_n) begin
      hr_word <= '1;
      hr_tog  <= 1'b1;
    end else begin
      hr_word <= data_in;
      hr_tog  <= ~hr_tog;
    end

  assign first = hr_tog != tog_seen;

  // pair bit 0 drives the high phase, bit 1 the low phase
  always_comb
    case (mode)
      M_REG:   fr_next = {data_in[0], data_in[0]};
      M_FDR:   fr_next = {data_in[1], data_in[0]};
      M_HDR:   fr_next = first ? hr_word[1:0] : hr_word[3:2];
      default: fr_next = {data_in[0], data_in[0]};
    endcase

  always_ff @(posedge clk_full or negedge clr_n or negedge set_n)
    if (!clr_n) begin
      fr_pair  <= '0;
      tog_seen <= 1'b0;
      ph       <= 1'b0;
    end else if (!set_n) begin
      fr_pair  <= '1;
      tog_seen <= 1'b1;
      ph       <= 1'b0;
    end else begin
      fr_pair  <= fr_next;
      tog_seen <= hr_tog;
      ph       <= first;
    end

  assign chain_in = (mode == M_BYP) ? {data_in[0], data_in[0]} : fr_pair;

  always_ff @(posedge clk_full or negedge clr_n or negedge set_n)
    if (!clr_n) begin
      for (int i = 0; i < DLY; i++) begin
        dq[i] <= '0;
        oq[i] <= 1'b0;
      end
    end else if (!set_n) begin
      for (int i = 0; i < DLY; i++) begin
        dq[i] <= '1;
        oq[i] <= 1'b0;
      end
    end else begin
      dq[0] <= chain_in;
      oq[0] <= oe_in;
      for (int i = 1; i < DLY; i++) begin
        dq[i] <= dq[i-1];
        oq[i] <= oq[i-1];
      end
    end

  assign pad_out = clk_full ? dq[LAST][0] : dq[LAST][1];
  assign pad_oe  = oq[LAST];

  // R6: clear holds the pad low and disabled
  p_clear_r6: assert property (@(negedge clk_full)
    !clr_n |-> (pad_out == 1'b0 && pad_oe == 1'b0));

  // R7: preset drives a disabled high
  p_preset_r7: assert property (@(negedge clk_full) disable iff (!clr_n)
    !set_n |-> (pad_out == 1'b1 && pad_oe == 1'b0));

  // R3: single-edge routes present the same bit in both phases
  p_single_edge_r3: assert property (@(posedge clk_full) disable iff (!clr_n || !set_n)
    (mode == M_BYP || mode == M_REG) |-> dq[LAST][0] == dq[LAST][1]);

  // R5: the first pair of a word is never taken twice in a row
  p_half_phase_r5: assert property (@(posedge clk_full) disable iff (!clr_n || !set_n)
    (mode == M_HDR && ph) |=> !ph);
endmodule

// File: tb/sim_ddr_out_path.sv
module sim_ddr_out_path;
  localparam int DLY = 2;
  localparam int N = 40;

  logic clk_half = 1'b0, clk_full = 1'b0;
  logic clr_n = 1'b1, set_n = 1'b1;
  logic [1:0] mode = 2'd0;
  logic [3:0] data_in = 4'd0;
  logic oe_in = 1'b0;
  logic pad_out, pad_oe;

  int total = 0, bad = 0;
  bit done = 0;
  logic exp_hi [64];
  logic exp_lo [64];
  logic exp_oe [64];

  ddr_out_path #(.DLY(DLY)) u0 (
    .clk_half(clk_half), .clk_full(clk_full), .clr_n(clr_n), .set_n(set_n),
    .mode(mode), .data_in(data_in), .oe_in(oe_in),
    .pad_out(pad_out), .pad_oe(pad_oe));

  initial forever begin
    #5 clk_full = 1'b1; clk_half = ~clk_half;
    #5 clk_full = 1'b0;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic put(input int idx, input logic hi, input logic lo);
    if (idx < 64) begin
      exp_hi[idx] = hi;
      exp_lo[idx] = lo;
    end
  endtask

  // R1: each mode run starts under clear, then follows the queue model
  task automatic run_mode(input logic [1:0] m, input string req);
    logic [3:0] w;
    logic hf;
    @(posedge clk_full); #1;
    clr_n = 1'b0; mode = m; data_in = 4'd0; oe_in = 1'b0;
    @(posedge clk_full); #2;
    chk("R6 reset pad_out", pad_out, 1'b0);
    chk("R6 reset pad_oe", pad_oe, 1'b0);
    for (int i = 0; i < 64; i++) begin
      exp_hi[i] = 1'b0; exp_lo[i] = 1'b0; exp_oe[i] = 1'b0;
    end
    for (int k = 0; k < N; k++) begin
      @(posedge clk_full); #1;
      if (k == 0) clr_n = 1'b1;
      hf = clk_half;
      w = 4'($urandom);
      oe_in = 1'($urandom);
      if (k + DLY < 64) exp_oe[k + DLY] = oe_in;
      case (m)
        2'd0: begin data_in = w; put(k + DLY, w[0], w[0]); end
        2'd1: begin data_in = w; put(k + 1 + DLY, w[0], w[0]); end
        2'd2: begin data_in = w; put(k + 1 + DLY, w[0], w[1]); end
        default: if (hf) begin
          data_in = w;
          put(k + 3 + DLY, w[0], w[1]);
          put(k + 4 + DLY, w[2], w[3]);
        end
      endcase
      #1;
      chk({req, " high phase"}, pad_out, exp_hi[k]);
      chk("R8 oe high phase", pad_oe, exp_oe[k]);
      #5;
      chk({req, " low phase"}, pad_out, exp_lo[k]);
      chk("R8 oe low phase", pad_oe, exp_oe[k]);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    run_mode(2'd0, "R2 bypass");
    run_mode(2'd1, "R3 packed");
    run_mode(2'd2, "R4 full ddr");
    run_mode(2'd3, "R5 half ddr");
    // R7 preset between edges, then R6 clear over preset
    @(posedge clk_full); #1;
    set_n = 1'b0;
    #1 chk("R7 preset high phase", pad_out, 1'b1);
    chk("R7 preset oe", pad_oe, 1'b0);
    #5 chk("R7 preset low phase", pad_out, 1'b1);
    @(posedge clk_full); #1;
    clr_n = 1'b0;
    #1 chk("R6 clear over preset high", pad_out, 1'b0);
    #5 chk("R6 clear over preset low", pad_out, 1'b0);
    chk("R6 clear oe", pad_oe, 1'b0);
    @(posedge clk_full); #1;
    set_n = 1'b1;
    @(posedge clk_full); #1;
    clr_n = 1'b1;
    #2 chk("R6 after release", pad_out, 1'b0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule